// File: doc/BRIEF.md
# Sparse Index-Matching Multiply-Accumulate Cell

This block is one processing cell of a two-dimensional systolic array that multiplies a column-packed sparse matrix by a dense vector. The cell holds a matrix entry, which is a signed weight and the column index it came from. It holds two such entries, one per matrix block, so the next block can be loaded while the current one computes. Vector elements arrive from above as a value, an index and a group-end marker. The cell passes them downward one cycle later, unchanged. A partial sum arrives from the left. The cell's registered partial-sum output feeds the neighbour on its right.

While a vector group streams past, the cell copies the value whose index equals its stored column index. When the group-end marker arrives, the cell adds the product of that copied value and its weight to the incoming partial sum. It then clears the copy. A cell whose active weight is zero forwards the left partial sum on every cycle and never multiplies. The arithmetic is signed 8-bit, and the sum is 32 bits wide and wraps.

Top module: `sparse_mac_pe`

## Requirements
- R1: An active-high synchronous reset clears the partial-sum output, the forwarded vector outputs, the captured value and both weight slots.
- R2: Bypass mode applies when the active weight is zero. The next partial-sum output equals the current left partial sum, whatever the index or end inputs are.
- R3: Hold mode applies when the weight is nonzero, the end flag is low and the vector index differs from the stored index. The partial-sum output and the captured value keep their values.
- R4: Latch mode applies when the weight is nonzero, the end flag is low and the indices are equal. The vector value is captured and the partial-sum output keeps its value. A later match in the same group replaces the earlier capture.
- R5: Accumulate mode applies when the weight is nonzero and the end flag is high. The next partial-sum output is the left partial sum plus the signed product of the captured value and the weight, modulo 2^32. The value and index that arrive with the end flag are not used for matching.
- R6: If no index matched during a group, the accumulate step forwards the left partial sum unchanged.
- R7: The captured value returns to zero after every accumulate step, so nothing from one group carries into the next.
- R8: The vector value, index and end flag appear on the downward outputs one cycle after they arrive, unchanged, in every mode.
- R9: When the load enable is high, the load value and index are written into the slot that `buf_sel` does not select. `buf_sel` = 0 makes slot 0 active and `buf_sel` = 1 makes slot 1 active. A load never changes the active entry.
- R10: Values and weights are two's-complement. Negative operands and the extreme value -128 give correctly signed products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Write the load entry into the inactive slot |
| ld_val | input | 8 | Weight to load (signed) |
| ld_idx | input | 16 | Column index to load |
| buf_sel | input | 1 | Selects the active slot |
| x_val_i | input | 8 | Vector value from above (signed) |
| x_idx_i | input | 16 | Vector index from above |
| x_end_i | input | 1 | Group-end marker from above |
| psum_i | input | 32 | Partial sum from the left (signed) |
| x_val_o | output | 8 | Vector value passed downward |
| x_idx_o | output | 16 | Vector index passed downward |
| x_end_o | output | 1 | Group-end marker passed downward |
| psum_o | output | 32 | Registered partial sum to the right (signed) |

## Verification
Several mode behaviours are checked on every cycle: the bypass pass-through of the left sum, the unchanged sum in hold and latch, the capture of the vector value on a match, the clearing of the capture after accumulate, the one-cycle downward forwarding and the protection of the active slot during loads. The arithmetic result of an accumulate can only be shown by the bench scenarios. These scenarios cover signed operands including -128, a group with no match, a group with two matches, an end flag that carries a matching index, and the sequence of loading a slot and then switching `buf_sel` to it.

// File: rtl/pe_pkg.sv
package pe_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD   = 2'd0,
      MODE_LATCH  = 2'd1,
      MODE_ACCUM  = 2'd2,
      MODE_BYPASS = 2'd3
   } pe_mode_e;
endpackage

// File: rtl/pe_entry_bank.sv
module pe_entry_bank #(
   parameter int VAL_W = 8,
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic [VAL_W-1:0] ld_val,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic             buf_sel,
   output logic [VAL_W-1:0] act_val,
   output logic [IDX_W-1:0] act_idx
);
   localparam int NSLOT = 2;

   logic [VAL_W-1:0] slot_val [NSLOT];
   logic [IDX_W-1:0] slot_idx [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      // a slot is written only while the other one is active
      logic wr_here;
      assign wr_here = ld_en && (buf_sel != 1'(s));
      always_ff @(posedge clk) begin
         if (rst) begin
            slot_val[s] <= '0;
            slot_idx[s] <= '0;
         end else if (wr_here) begin
            slot_val[s] <= ld_val;
            slot_idx[s] <= ld_idx;
         end
      end
   end

   assign act_val = slot_val[buf_sel];
   assign act_idx = slot_idx[buf_sel];
endmodule

// File: rtl/pe_mode_decode.sv
module pe_mode_decode
   import pe_pkg::*;
#(
   parameter int VAL_W = 8,
   parameter int IDX_W = 16
) (
   input  logic [VAL_W-1:0] act_val,
   input  logic [IDX_W-1:0] act_idx,
   input  logic [IDX_W-1:0] x_idx,
   input  logic             x_end,
   output pe_mode_e         mode
);
   logic idx_hit;
   assign idx_hit = (x_idx == act_idx);

   always_comb begin
      if (act_val == '0)  mode = MODE_BYPASS;
      else if (x_end)     mode = MODE_ACCUM;
      else if (idx_hit)   mode = MODE_LATCH;
      else                mode = MODE_HOLD;
   end
endmodule

// File: rtl/pe_mac_unit.sv
module pe_mac_unit #(
   parameter int VAL_W     = 8,
   parameter int ACC_W     = 32,
   parameter bit SIGNED_OP = 1'b1
) (
   input  logic [VAL_W-1:0] held_val,
   input  logic [VAL_W-1:0] weight,
   input  logic [ACC_W-1:0] acc_in,
   output logic [ACC_W-1:0] acc_out
);
   localparam int PROD_W = 2 * VAL_W;
   localparam int EXT_W  = ACC_W - PROD_W;

   logic [PROD_W-1:0] prod;
   logic [ACC_W-1:0]  prod_ext;

   if (SIGNED_OP) begin : g_signed
      assign prod     = PROD_W'($signed(held_val) * $signed(weight));
      assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
   end else begin : g_unsigned
      assign prod     = PROD_W'(held_val * weight);
      assign prod_ext = {{EXT_W{1'b0}}, prod};
   end

   assign acc_out = acc_in + prod_ext;
endmodule

// File: rtl/sparse_mac_pe.sv
module sparse_mac_pe
   import pe_pkg::*;
#(
   parameter int VAL_W     = 8,
   parameter int IDX_W     = 16,
   parameter int ACC_W     = 32,
   parameter bit SIGNED_OP = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic [VAL_W-1:0] ld_val,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic             buf_sel,
   input  logic [VAL_W-1:0] x_val_i,
   input  logic [IDX_W-1:0] x_idx_i,
   input  logic             x_end_i,
   input  logic [ACC_W-1:0] psum_i,
   output logic [VAL_W-1:0] x_val_o,
   output logic [IDX_W-1:0] x_idx_o,
   output logic             x_end_o,
   output logic [ACC_W-1:0] psum_o
);
   if (ACC_W <= 2 * VAL_W) begin : g_bad_acc
      $error("ACC_W must exceed twice VAL_W");
   end
   if (VAL_W < 2 || IDX_W < 1) begin : g_bad_w
      $error("VAL_W or IDX_W too small");
   end

   logic [VAL_W-1:0] act_val;
   logic [IDX_W-1:0] act_idx;
   pe_mode_e         mode_w;
   logic [VAL_W-1:0] held_q;
   logic [ACC_W-1:0] mac_sum;

   pe_entry_bank #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_val), .ld_idx(ld_idx),
      .buf_sel(buf_sel), .act_val(act_val), .act_idx(act_idx)
   );

   pe_mode_decode #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_dec (
      .act_val(act_val), .act_idx(act_idx), .x_idx(x_idx_i),
      .x_end(x_end_i), .mode(mode_w)
   );

   pe_mac_unit #(.VAL_W(VAL_W), .ACC_W(ACC_W), .SIGNED_OP(SIGNED_OP)) u_mac (
      .held_val(held_q), .weight(act_val), .acc_in(psum_i), .acc_out(mac_sum)
   );

   // downward vector pipeline stage, mode independent
   always_ff @(posedge clk) begin
      if (rst) begin
         x_val_o <= '0;
         x_idx_o <= '0;
         x_end_o <= 1'b0;
      end else begin
         x_val_o <= x_val_i;
         x_idx_o <= x_idx_i;
         x_end_o <= x_end_i;
      end
   end

   // captured value and rightward partial sum
   always_ff @(posedge clk) begin
      if (rst) begin
         held_q <= '0;
         psum_o <= '0;
      end else begin
         unique case (mode_w)
            MODE_LATCH:  held_q <= x_val_i;
            MODE_ACCUM: begin
               psum_o <= mac_sum;
               held_q <= '0;
            end
            MODE_BYPASS: psum_o <= psum_i;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sparse_mac_pe_chk.sv
module sparse_mac_pe_chk
   import pe_pkg::*;
#(
   parameter int VAL_W = 8,
   parameter int IDX_W = 16,
   parameter int ACC_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             ld_en,
   input logic             buf_sel,
   input pe_mode_e         mode_w,
   input logic [VAL_W-1:0] held_q,
   input logic [VAL_W-1:0] act_val,
   input logic [IDX_W-1:0] act_idx,
   input logic [VAL_W-1:0] x_val_i,
   input logic [IDX_W-1:0] x_idx_i,
   input logic             x_end_i,
   input logic [ACC_W-1:0] psum_i,
   input logic [VAL_W-1:0] x_val_o,
   input logic [IDX_W-1:0] x_idx_o,
   input logic             x_end_o,
   input logic [ACC_W-1:0] psum_o
);
   a_r2_bypass_passes_left: assert property (@(posedge clk) disable iff (rst)
      (mode_w == MODE_BYPASS) |=> (psum_o == $past(psum_i)));

   a_r3_hold_keeps_state: assert property (@(posedge clk) disable iff (rst)
      (mode_w == MODE_HOLD) |=> ($stable(psum_o) && $stable(held_q)));

   a_r4_latch_captures: assert property (@(posedge clk) disable iff (rst)
      (mode_w == MODE_LATCH) |=> ($stable(psum_o) && held_q == $past(x_val_i)));

   a_r7_clear_after_accum: assert property (@(posedge clk) disable iff (rst)
      (mode_w == MODE_ACCUM) |=> (held_q == '0));

   a_r8_forward_down: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (x_val_o == $past(x_val_i) && x_idx_o == $past(x_idx_i)
                && x_end_o == $past(x_end_i)));

   a_r9_load_spares_active: assert property (@(posedge clk) disable iff (rst)
      ($past(ld_en) && $stable(buf_sel)) |->
         (act_val == $past(act_val) && act_idx == $past(act_idx)));
endmodule

bind sparse_mac_pe sparse_mac_pe_chk #(.VAL_W(VAL_W), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst(rst), .ld_en(ld_en), .buf_sel(buf_sel), .mode_w(mode_w),
   .held_q(held_q), .act_val(act_val), .act_idx(act_idx),
   .x_val_i(x_val_i), .x_idx_i(x_idx_i), .x_end_i(x_end_i), .psum_i(psum_i),
   .x_val_o(x_val_o), .x_idx_o(x_idx_o), .x_end_o(x_end_o), .psum_o(psum_o)
);

// File: tb/tb_sparse_mac_pe.sv
module tb_sparse_mac_pe;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_en = 1'b0;
   logic [7:0]  ld_val = '0;
   logic [15:0] ld_idx = '0;
   logic        buf_sel = 1'b0;
   logic [7:0]  x_val_i = '0;
   logic [15:0] x_idx_i = '0;
   logic        x_end_i = 1'b0;
   logic [31:0] psum_i = '0;
   logic [7:0]  x_val_o;
   logic [15:0] x_idx_o;
   logic        x_end_o;
   logic [31:0] psum_o;

   int n_chk = 0;
   int n_bad = 0;

   sparse_mac_pe dut (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_val), .ld_idx(ld_idx),
      .buf_sel(buf_sel), .x_val_i(x_val_i), .x_idx_i(x_idx_i), .x_end_i(x_end_i),
      .psum_i(psum_i), .x_val_o(x_val_o), .x_idx_o(x_idx_o), .x_end_o(x_end_o),
      .psum_o(psum_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d (0x%08h) expected %0d (0x%08h)", req,
                  $signed(act), act, $signed(exp), exp);
      end
   endtask

   // apply one vector beat for one clock, then check downward forwarding (R8)
   task automatic beat(input logic [7:0] v, input logic [15:0] ix, input logic e,
                       input logic [31:0] ps);
      x_val_i = v; x_idx_i = ix; x_end_i = e; psum_i = ps;
      @(posedge clk); #1;
      check("R8 val", 32'(x_val_o), 32'(v));
      check("R8 idx", 32'(x_idx_o), 32'(ix));
      check("R8 end", 32'(x_end_o), 32'(e));
      x_end_i = 1'b0;
   endtask

   task automatic load(input logic [7:0] w, input logic [15:0] ix);
      ld_en = 1'b1; ld_val = w; ld_idx = ix;
      @(posedge clk); #1;
      ld_en = 1'b0;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      rst = 1'b0;
      check("R1 psum", psum_o, 32'd0);
      check("R1 xval", 32'(x_val_o), 32'd0);
      check("R1 xend", 32'(x_end_o), 32'd0);
   endtask

   task automatic t_bypass;
      // both slots cleared: weight zero, so left sum passes through even with end set
      beat(8'd9, 16'd0, 1'b1, 32'd123);
      check("R1 R2 bypass after reset", psum_o, 32'd123);
      beat(8'd4, 16'd0, 1'b0, 32'hFFFF_FFF0);
      check("R2 bypass idx match", psum_o, 32'hFFFF_FFF0);
   endtask

   task automatic t_basic;
      buf_sel = 1'b0;
      load(8'd3, 16'd5);          // goes to slot 1
      beat(8'd0, 16'd0, 1'b0, 32'd77);
      check("R9 slot0 still active (bypass)", psum_o, 32'd77);
      buf_sel = 1'b1;
      beat(8'd1, 16'd7, 1'b0, 32'd999);
      check("R3 hold mismatch", psum_o, 32'd77);
      beat(8'd10, 16'd5, 1'b0, 32'd888);
      check("R4 latch keeps sum", psum_o, 32'd77);
      beat(8'd50, 16'd9, 1'b0, 32'd555);
      check("R3 hold after latch", psum_o, 32'd77);
      beat(8'd77, 16'd5, 1'b1, 32'd100);
      check("R5 accumulate 100+10*3", psum_o, 32'd130);
      beat(8'd0, 16'd1, 1'b1, 32'd200);
      check("R7 cleared after accum", psum_o, 32'd200);
   endtask

   task automatic t_nomatch_and_rematch;
      beat(8'd6, 16'd8, 1'b0, 32'd1);
      beat(8'd6, 16'd4, 1'b0, 32'd2);
      beat(8'd6, 16'd5, 1'b1, 32'd40);
      check("R6 no match forwards sum", psum_o, 32'd40);
      beat(8'd4, 16'd5, 1'b0, 32'd0);
      beat(8'd6, 16'd5, 1'b0, 32'd0);
      beat(8'd0, 16'd0, 1'b1, 32'd1000);
      check("R4 last match wins", psum_o, 32'd1018);
   endtask

   task automatic t_signed_and_swap;
      load(8'hF9, 16'd2);         // -7 into slot 0 while slot 1 active
      beat(8'd2, 16'd5, 1'b0, 32'd0);
      beat(8'd0, 16'd0, 1'b1, 32'd10);
      check("R9 load spares active slot", psum_o, 32'd16);
      buf_sel = 1'b0;
      beat(8'h80, 16'd2, 1'b0, 32'd0);
      beat(8'd0, 16'd0, 1'b1, 32'hFFFF_FFFB);
      check("R10 -5 + -128*-7", psum_o, 32'd891);
      beat(8'd127, 16'd2, 1'b0, 32'd0);
      beat(8'd0, 16'd0, 1'b1, 32'd0);
      check("R10 127*-7", psum_o, 32'hFFFF_FC87);
      beat(8'd1, 16'd2, 1'b0, 32'd0);
      beat(8'd0, 16'd0, 1'b1, 32'h7FFF_FFFF);
      check("R10 wrap at 2^32", psum_o, 32'h7FFF_FFF8);
   endtask

   task automatic t_end_ignores_match;
      // a matching index on the end beat itself is not captured
      beat(8'd50, 16'd2, 1'b1, 32'd3);
      check("R5 end beat not matched", psum_o, 32'd3);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      t_bypass();
      t_basic();
      t_nomatch_and_rematch();
      t_signed_and_swap();
      t_end_ignores_match();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule